// File: doc/BRIEF.md
# Multiplexed Character Display Scan Sequencer

This block refreshes an eight-position multiplexed character display from a small character store held outside it. A single-cycle oscillator enable is first divided by a prescaler, and every prescaler wrap moves a character index on by one position. The index is both the read address into the character store and the source of a one-hot, active-high character select. The 6-bit code read back is handed unchanged to an external font lookup. The 17 segment bits that the lookup returns (sixteen strokes plus a decimal point) are registered onto the segment outputs.

Three conditions darken the outputs. The first is a short blanking window at the start of every character slot, which stops the previous character's segments from ghosting onto the next position. The second is any write that is really storing data into the character store. The third is shutdown. Shutdown also returns the whole timing chain to zero, so scanning starts again cleanly from the first character once it is released. The character store is left untouched.

Top module: `disp_scan_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `char_sel` and `seg_out` are all zero and `mem_addr` is 0.
- R2: The character index advances by exactly one after every `PRESCALE` (default 64) cycles in which `tick` is high. Cycles with `tick` low never move the prescaler or the index.
- R3: `mem_addr` equals the character index. One cycle after an unblanked cycle, `char_sel` has exactly one bit set, and that bit is at position `mem_addr` of the previous cycle (bit 0 is the first character).
- R4: While the prescaler count is below `BLANK_TICKS` (default 1, so only count 0), the next cycle shows `char_sel` and `seg_out` all zero. `char_sel` never has more than one bit set.
- R5: `font_code` equals `mem_code` in the same cycle. In an unblanked cycle, `seg_out` in the next cycle equals the `font_seg` value of this cycle.
- R6: A cycle with `wr_busy` high makes `char_sel` and `seg_out` zero in the next cycle. The prescaler and the index keep counting as if no write had occurred.
- R7: A cycle with `shutdown` high clears the prescaler and the index to 0, so `mem_addr` reads 0 in the next cycle, and makes `char_sel` and `seg_out` zero in the next cycle. `tick` has no effect while `shutdown` is high.
- R8: After the last position (index 7), the next wrap returns the index to 0.
- R9: After `shutdown` is released with `tick` high every cycle, the first cycle is blanked and the second lights character 0 (`char_sel` = 8'h01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle oscillator enable |
| shutdown | input | 1 | Clears the timing chain and darkens the outputs |
| wr_busy | input | 1 | A storing write is in progress; darkens the outputs |
| mem_addr | output | 3 | Character store read address (character index) |
| mem_code | input | 6 | Code read from the character store at `mem_addr` |
| font_code | output | 6 | Code forwarded to the font lookup |
| font_seg | input | 17 | Segment pattern returned by the font lookup |
| char_sel | output | 8 | One-hot active-high character select |
| seg_out | output | 17 | Segment outputs, zero when darkened |

## Verification
The hard cases are those where a slot change falls in the same cycle as a darkening condition. A prescaler wrap can land together with a `wr_busy` pulse, or together with a rising `shutdown`. Directed tasks place the write pulses and the shutdown assertion on the exact cycle in which the prescaler reaches its last count. The bench then compares the outputs on every cycle against a cycle-level model derived from the requirements. This confirms that a write darkens the outputs without losing or duplicating a step, and that shutdown wins over a wrap in the same cycle, leaving the index at 0.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;

    localparam int DEF_PRESCALE = 64;
    localparam int DEF_CHARS    = 8;
    localparam int DEF_CODE_W   = 6;
    localparam int DEF_SEG_W    = 17;

    // Reasons the outputs can be forced dark, gathered per cycle.
    typedef struct packed {
        logic off;    // shutdown or reset
        logic quiet;  // storing write in progress
        logic blank;  // inter-character gap
    } scan_ctl_t;

    typedef enum logic [1:0] {
        OUT_SHOW        = 2'd0,
        OUT_BLANK_SLOT  = 2'd1,
        OUT_QUIET_WRITE = 2'd2,
        OUT_OFF         = 2'd3
    } out_mode_e;

    function automatic out_mode_e pick_mode(input scan_ctl_t c);
        if (c.off)        return OUT_OFF;
        else if (c.quiet) return OUT_QUIET_WRITE;
        else if (c.blank) return OUT_BLANK_SLOT;
        else              return OUT_SHOW;
    endfunction

endpackage

// File: rtl/scan_prescaler.sv
module scan_prescaler #(
    parameter int PRESCALE    = 64,
    parameter int BLANK_TICKS = 1,
    localparam int PRE_W      = $clog2(PRESCALE)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic wrap,
    output logic blank
);
    logic [PRE_W-1:0] pre_cnt;
    logic             at_top;

    assign at_top = (pre_cnt == PRE_W'(PRESCALE - 1));
    assign wrap   = tick && at_top;
    assign blank  = (pre_cnt < PRE_W'(BLANK_TICKS));

    always_ff @(posedge clk) begin
        if (rst || clear)   pre_cnt <= '0;
        else if (tick) begin
            if (at_top)     pre_cnt <= '0;
            else            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R7: clearing forces the count back to zero
    assert_pre_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clear |=> pre_cnt == '0);

    // R2: no tick, no movement
    assert_pre_hold_R2: assert property (@(posedge clk) disable iff (rst || clear)
        !tick |=> $stable(pre_cnt));

endmodule

// File: rtl/scan_char_counter.sv
module scan_char_counter #(
    parameter int NUM_CHARS = 8,
    localparam int IDX_W    = $clog2(NUM_CHARS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    logic last;
    assign last = (idx == IDX_W'(NUM_CHARS - 1));

    always_ff @(posedge clk) begin
        if (rst || clear)  idx <= '0;
        else if (step) begin
            if (last)      idx <= '0;
            else           idx <= idx + 1'b1;
        end
    end

    // R2: index holds between prescaler wraps
    assert_char_hold_R2: assert property (@(posedge clk) disable iff (rst || clear)
        !step |=> $stable(idx));

    // R8: last position wraps to the first
    assert_char_wrap_R8: assert property (@(posedge clk) disable iff (rst || clear)
        (step && idx == IDX_W'(NUM_CHARS - 1)) |=> idx == '0);

endmodule

// File: rtl/scan_out_stage.sv
module scan_out_stage
    import disp_scan_pkg::*;
#(
    parameter int NUM_CHARS = 8,
    parameter int SEG_W     = 17,
    localparam int IDX_W    = $clog2(NUM_CHARS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  out_mode_e            mode,
    input  logic [IDX_W-1:0]     idx,
    input  logic [SEG_W-1:0]     seg_in,
    output logic [NUM_CHARS-1:0] char_sel,
    output logic [SEG_W-1:0]     seg_out
);
    logic [NUM_CHARS-1:0] sel_dec;

    for (genvar g = 0; g < NUM_CHARS; g++) begin : g_dec
        assign sel_dec[g] = (idx == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst || mode != OUT_SHOW) begin
            char_sel <= '0;
            seg_out  <= '0;
        end else begin
            char_sel <= sel_dec;
            seg_out  <= seg_in;
        end
    end

    // R4: never two characters lit at once
    assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(char_sel));

    // R5: segments dark whenever select is dark
    assert_seg_dark_R5: assert property (@(posedge clk) disable iff (rst)
        (mode != OUT_SHOW) |=> seg_out == '0);

endmodule

// File: rtl/disp_scan_seq.sv
module disp_scan_seq
    import disp_scan_pkg::*;
#(
    parameter int PRESCALE    = DEF_PRESCALE,
    parameter int BLANK_TICKS = 1,
    parameter int NUM_CHARS   = DEF_CHARS,
    parameter int CODE_W      = DEF_CODE_W,
    parameter int SEG_W       = DEF_SEG_W,
    localparam int IDX_W      = $clog2(NUM_CHARS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 shutdown,
    input  logic                 wr_busy,
    output logic [IDX_W-1:0]     mem_addr,
    input  logic [CODE_W-1:0]    mem_code,
    output logic [CODE_W-1:0]    font_code,
    input  logic [SEG_W-1:0]     font_seg,
    output logic [NUM_CHARS-1:0] char_sel,
    output logic [SEG_W-1:0]     seg_out
);
    logic       wrap;
    logic       blank;
    logic [IDX_W-1:0] idx;
    scan_ctl_t  ctl;
    out_mode_e  mode;

    scan_prescaler #(
        .PRESCALE    (PRESCALE),
        .BLANK_TICKS (BLANK_TICKS)
    ) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (shutdown),
        .tick  (tick),
        .wrap  (wrap),
        .blank (blank)
    );

    scan_char_counter #(
        .NUM_CHARS (NUM_CHARS)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (shutdown),
        .step  (wrap),
        .idx   (idx)
    );

    assign ctl.off   = shutdown;
    assign ctl.quiet = wr_busy;
    assign ctl.blank = blank;
    assign mode      = pick_mode(ctl);

    assign mem_addr  = idx;
    assign font_code = mem_code;

    scan_out_stage #(
        .NUM_CHARS (NUM_CHARS),
        .SEG_W     (SEG_W)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .idx      (idx),
        .seg_in   (font_seg),
        .char_sel (char_sel),
        .seg_out  (seg_out)
    );

    // R6: a storing write darkens the next cycle
    assert_quiet_write_R6: assert property (@(posedge clk) disable iff (rst)
        wr_busy |=> (char_sel == '0 && seg_out == '0));

    // R7: shutdown darkens and parks the address at zero
    assert_shutdown_dark_R7: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> (char_sel == '0 && seg_out == '0 && mem_addr == '0));

    // R4: slot-start gap darkens the select
    assert_gap_dark_R4: assert property (@(posedge clk) disable iff (rst)
        blank |=> char_sel == '0);

    // R3: an undisturbed cycle lights exactly one character
    assert_one_lit_R3: assert property (@(posedge clk) disable iff (rst)
        (!shutdown && !wr_busy && !blank) |=> $countones(char_sel) == 1);

endmodule

// File: tb/disp_scan_seq_tb.sv
module disp_scan_seq_tb;

    logic        clk = 1'b0;
    logic        rst, tick, shutdown, wr_busy;
    logic [2:0]  mem_addr;
    logic [5:0]  mem_code, font_code;
    logic [16:0] font_seg, seg_out;
    logic [7:0]  char_sel;

    logic [5:0]  mem [8];
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [16:0] fake_font(input logic [5:0] c);
        return {c[0], c, ~c, c[5:2]};
    endfunction

    assign mem_code = mem[mem_addr];
    assign font_seg = fake_font(font_code);

    disp_scan_seq u_dut (
        .clk(clk), .rst(rst), .tick(tick), .shutdown(shutdown), .wr_busy(wr_busy),
        .mem_addr(mem_addr), .mem_code(mem_code), .font_code(font_code),
        .font_seg(font_seg), .char_sel(char_sel), .seg_out(seg_out)
    );

    // Reference model built from the requirements
    int          m_pre = 0;
    int          m_idx = 0;
    logic [7:0]  e_sel = '0;
    logic [16:0] e_seg = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst || shutdown || wr_busy || m_pre < 1) begin
            e_sel <= '0;
            e_seg <= '0;
        end else begin
            e_sel <= 8'(1 << m_idx);
            e_seg <= fake_font(mem[m_idx]);
        end
        if (rst || shutdown) begin
            m_pre <= 0;
            m_idx <= 0;
        end else if (tick) begin
            m_pre <= (m_pre == 63) ? 0 : m_pre + 1;
            if (m_pre == 63) m_idx <= (m_idx == 7) ? 0 : m_idx + 1;
        end
    end

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic check_model(string tag);
        check_eq({tag, " char_sel"}, 32'(char_sel), 32'(e_sel));
        check_eq({tag, " seg_out"},  32'(seg_out),  32'(e_seg));
        check_eq({tag, " mem_addr"}, 32'(mem_addr), 32'(m_idx));
        check_eq({tag, " font_code"}, 32'(font_code), 32'(mem[mem_addr]));
    endtask

    // Run n cycles, ticking every 'every' cycles, model-checking each cycle
    task automatic run(int n, int every, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_model(tag);
            tick = (every > 0) && (i % every == 0);
        end
    endtask

    task automatic t_reset;
        rst = 1; tick = 1; shutdown = 0; wr_busy = 0;
        repeat (3) @(negedge clk);
        check_eq("R1 reset char_sel", 32'(char_sel), 0);
        check_eq("R1 reset seg_out", 32'(seg_out), 0);
        check_eq("R1 reset mem_addr", 32'(mem_addr), 0);
        rst = 0;
        @(negedge clk);
        check_eq("R1 post-reset char_sel", 32'(char_sel), 0);
        check_eq("R1 post-reset mem_addr", 32'(mem_addr), 0);
    endtask

    task automatic t_scan_full;
        logic [7:0] seen = '0;
        bit saw_last = 0, wrapped = 0;
        for (int i = 0; i < 1100; i++) begin
            @(negedge clk);
            check_model("R3 scan");
            seen |= char_sel;
            if (mem_addr == 3'd7) saw_last = 1;
            if (saw_last && mem_addr == 3'd0) wrapped = 1;
            tick = 1;
        end
        check_eq("R3 every character lit", 32'(seen), 32'hFF);
        check_eq("R8 index wrapped 7->0", 32'(wrapped), 1);
    endtask

    task automatic t_gap_count(int every, int n, int exp_dark, string tag);
        int dark = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_model(tag);
            if (char_sel == '0) dark++;
            tick = (i % every == 0);
        end
        check_eq({tag, " dark cycles"}, 32'(dark), 32'(exp_dark));
    endtask

    task automatic t_write;
        run(10, 1, "R6 lead");
        wr_busy = 1;
        @(negedge clk);
        check_eq("R6 write dark sel", 32'(char_sel), 0);
        check_eq("R6 write dark seg", 32'(seg_out), 0);
        check_model("R6 write");
        wr_busy = 0;
        // align a 3-cycle write with the prescaler's last count
        while (m_pre != 62) run(1, 1, "R6 align");
        wr_busy = 1;
        run(3, 1, "R6 write at wrap");
        wr_busy = 0;
        run(200, 1, "R2 after write");
    endtask

    task automatic t_shutdown;
        while (m_pre != 63) run(1, 1, "R7 align");
        shutdown = 1;   // lands together with a wrap
        run(20, 1, "R7 shutdown");
        check_eq("R7 shutdown addr", 32'(mem_addr), 0);
        check_eq("R7 shutdown dark", 32'(char_sel), 0);
        shutdown = 0;
        tick = 1;
        @(negedge clk);
        check_eq("R9 first cycle blank", 32'(char_sel), 0);
        @(negedge clk);
        check_eq("R9 second cycle char 0", 32'(char_sel), 32'h01);
        check_model("R9 restart");
        run(600, 1, "R9 rescan");
    endtask

    task automatic t_font;
        for (int k = 0; k < 8; k++) mem[k] = 6'(63 - 5 * k);
        run(600, 1, "R5 new font");
        for (int k = 0; k < 8; k++) mem[k] = 6'h20;
        run(100, 1, "R5 blank code");
    endtask

    initial begin
        for (int k = 0; k < 8; k++) mem[k] = 6'(7 * k + 5);
        rst = 1; tick = 0; shutdown = 0; wr_busy = 0;
        t_reset();
        t_scan_full();
        t_gap_count(1, 512, 8, "R4 gaps dense");
        run(300, 4, "R2 sparse warm");
        t_gap_count(4, 512, 8, "R2 gaps sparse");
        run(100, 0, "R2 no tick");
        t_write();
        t_shutdown();
        t_font();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule